// File: doc/BRIEF.md
# Serial EEPROM Target Controller

This block is the two-wire bus target side of a byte-addressed non-volatile memory. SCL and SDA reach it already synchronized to the system clock. It drives SDA only through an open-drain enable. The block finds START and STOP conditions on the bus and checks the device address byte. For a write it takes in a two-byte memory address and then streams data bytes to a page write engine. For a read it streams bytes from a synchronous memory read port back to the master.

One address pointer is shared by reads and writes and keeps its value between transactions. This gives three kinds of read. A current-address read needs no address phase. A random read first sends a write header that carries only the address, then a repeated START. A sequential read keeps going for as long as the master acknowledges. While the page write engine reports an internal programming cycle, the block does not acknowledge its device address. A host can therefore poll for completion.

The memory read port has one cycle of latency: `rd_data` must be valid in the clock cycle after the one in which `rd_en` is high. Each SCL phase, high or low, must last at least three system clocks.

Top module: `ser_mem_target`

## Requirements
- R1: The device address byte is 1010, then `strap_i[2:0]`, then R/W in bit 0, where 1 means read. The block acknowledges a matching byte by setting `sda_oe` = 1 (SDA pulled low) during the ninth clock. A byte that does not match gets no ACK. All later traffic is then ignored and leaves the pointer unchanged until the next START or STOP.
- R2: A write header is followed by two address bytes, high byte first, and each one is acknowledged. Only the low 4 bits of the high byte are used, which gives a 12-bit address. Its upper 4 bits are ignored.
- R3: Each data byte of a write is acknowledged and shown for one cycle on `wr_valid`/`wr_addr`/`wr_data`. After each byte the pointer advances only in its low 6 bits, so it wraps inside a 64-byte page. Bits 11..6 do not change.
- R4: `wr_commit` pulses for one cycle on a STOP that follows at least one data byte since the last START. A repeated START discards the uncommitted bytes, and no commit follows.
- R5: A read header with no address phase returns the byte at the pointer. The pointer holds the last accessed address plus one and keeps its value across transactions.
- R6: A random read works as follows. A write header and two address bytes are sent, then a repeated START and a read header. The data then comes from the address just loaded.
- R7: When the master ACKs a read byte (SDA low in the ninth clock), the next byte follows. The full 12-bit address increments, so 4095 is followed by 0.
- R8: A NACK after a read byte ends the transfer. SDA is released and the pointer is left at the last byte sent plus one.
- R9: While `busy_i` is high at the end of the device address byte, no ACK is given. An acknowledge comes back once `busy_i` has fallen.
- R10: `sda_oe` changes only while SCL is low.
- R11: A START in the middle of a byte aborts that byte and restarts address matching. A STOP in the middle of a byte returns the block to idle. In both cases the pointer is left unchanged.
- R12: After reset `sda_oe`, `wr_valid`, `wr_commit` and `rd_en` are 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data (wired line level) |
| strap_i | input | 3 | Low three bits of the device address |
| busy_i | input | 1 | Internal programming cycle in progress |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_valid | output | 1 | One-cycle pulse: a write data byte was received |
| wr_addr | output | 12 | Address of the received byte |
| wr_data | output | 8 | Received byte |
| wr_commit | output | 1 | One-cycle pulse: program the collected page |
| rd_en | output | 1 | Read request to the memory port |
| rd_addr | output | 12 | Read address (current pointer) |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |

## Verification
The hardest situation to reach from the ports is ACK withholding during a programming cycle. It needs a committed write and a busy window that follows it. The bench contains a small page-engine model that turns every `wr_commit` into a fixed busy interval. It polls with write headers right after the STOP until an ACK comes back. It then reads the page back across the in-page wrap point. The 4095-to-0 wrap is reached directly by a random read placed two bytes below the top of the array.

// File: rtl/ser_mem_pkg.sv
package ser_mem_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_RDAT,
      ST_SKIP
   } tgt_state_t;
endpackage

// File: rtl/bus_edge_detect.sv
module bus_edge_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   // Data edges while the clock stays high are bus conditions
   assign scl_rise  = scl_i & ~scl_q;
   assign scl_fall  = ~scl_i & scl_q;
   assign start_det = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/mem_addr_ptr.sv
module mem_addr_ptr #(
   parameter int ADDR_W = 12,
   parameter int PAGE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc_page,
   input  logic              inc_full,
   output logic [ADDR_W-1:0] ptr
);
   logic [ADDR_W-1:0] page_next;

   generate
      if (PAGE_W == ADDR_W) begin : g_flat
         assign page_next = ptr + ADDR_W'(1);
      end else begin : g_split
         assign page_next = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};

         // R3: page stepping never touches the page number
         assert_page_upper_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            inc_page |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr <= '0;
      else if (load)     ptr <= load_val;
      else if (inc_page) ptr <= page_next;
      else if (inc_full) ptr <= ptr + ADDR_W'(1);
   end
endmodule

// File: rtl/ser_mem_target.sv
module ser_mem_target
   import ser_mem_pkg::*;
#(
   parameter int          ADDR_W   = 12,
   parameter int          PAGE_W   = 6,
   parameter logic [3:0]  DEV_CODE = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [2:0]        strap_i,
   input  logic              busy_i,
   output logic              sda_oe,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              wr_commit,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data
);
   localparam int HI_W = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
         $error("ADDR_W must lie in 9..16");
      end
      if (PAGE_W < 2 || PAGE_W > ADDR_W) begin : g_bad_page_w
         $error("PAGE_W must lie in 2..ADDR_W");
      end
   endgenerate

   logic scl_rise, scl_fall, start_det, stop_det;
   tgt_state_t state;
   logic [3:0] cnt;
   logic [7:0] rx, shreg, tx_buf;
   logic [HI_W-1:0] hi;
   logic ack_drive, tx_on, rw, mack, wr_pend, rd_pend;
   logic byte_end, ack_end, dev_ok;
   logic ptr_load, ptr_inc_page, ptr_inc_full;
   logic [ADDR_W-1:0] ptr;

   bus_edge_detect u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   always_comb begin
      byte_end     = scl_fall && (cnt == 4'd8);
      ack_end      = scl_fall && (cnt == 4'd9);
      dev_ok       = (rx[7:1] == {DEV_CODE, strap_i}) && !busy_i;
      ptr_load     = byte_end && (state == ST_ALO);
      ptr_inc_page = byte_end && (state == ST_WDAT);
      ptr_inc_full = ack_end && (((state == ST_DEV) && rw) || ((state == ST_RDAT) && mack));
   end

   mem_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ptr_load),
      .load_val({hi, rx}),
      .inc_page(ptr_inc_page),
      .inc_full(ptr_inc_full),
      .ptr     (ptr)
   );

   assign rd_addr = ptr;
   assign sda_oe  = tx_on ? ~shreg[7] : ack_drive;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;   cnt <= '0;       rx <= '0;
         shreg <= '0;        tx_buf <= '0;    hi <= '0;
         ack_drive <= 1'b0;  tx_on <= 1'b0;   rw <= 1'b0;
         mack <= 1'b0;       wr_pend <= 1'b0; rd_pend <= 1'b0;
         wr_valid <= 1'b0;   wr_addr <= '0;   wr_data <= '0;
         wr_commit <= 1'b0;  rd_en <= 1'b0;
      end else begin
         wr_valid  <= 1'b0;
         wr_commit <= 1'b0;
         rd_en     <= 1'b0;
         rd_pend   <= rd_en;
         if (rd_pend) tx_buf <= rd_data;

         if (start_det) begin
            state <= ST_DEV;  cnt <= '0;
            ack_drive <= 1'b0; tx_on <= 1'b0; wr_pend <= 1'b0;
         end else if (stop_det) begin
            state <= ST_IDLE; cnt <= '0;
            ack_drive <= 1'b0; tx_on <= 1'b0;
            wr_commit <= wr_pend; wr_pend <= 1'b0;
         end else if (state != ST_IDLE && state != ST_SKIP) begin
            if (scl_rise) begin
               if (cnt < 4'd8) begin
                  rx  <= {rx[6:0], sda_i};
                  cnt <= cnt + 4'd1;
               end else if (cnt == 4'd9) begin
                  mack <= !sda_i;
               end
            end
            if (byte_end) begin
               cnt   <= 4'd9;
               tx_on <= 1'b0;
               case (state)
                  ST_DEV: begin
                     if (dev_ok) begin
                        ack_drive <= 1'b1;
                        rw        <= rx[0];
                        rd_en     <= rx[0];
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
                  ST_AHI: begin
                     ack_drive <= 1'b1;
                     hi        <= rx[HI_W-1:0];
                  end
                  ST_ALO:  ack_drive <= 1'b1;
                  ST_WDAT: begin
                     ack_drive <= 1'b1;
                     wr_valid  <= 1'b1;
                     wr_addr   <= ptr;
                     wr_data   <= rx;
                     wr_pend   <= 1'b1;
                  end
                  ST_RDAT: rd_en <= 1'b1;
                  default: ;
               endcase
            end else if (ack_end) begin
               cnt       <= '0;
               ack_drive <= 1'b0;
               case (state)
                  ST_DEV: begin
                     if (rw) begin
                        state <= ST_RDAT;
                        tx_on <= 1'b1;
                        shreg <= tx_buf;
                     end else begin
                        state <= ST_AHI;
                     end
                  end
                  ST_AHI: state <= ST_ALO;
                  ST_ALO: state <= ST_WDAT;
                  ST_RDAT: begin
                     if (mack) begin
                        tx_on <= 1'b1;
                        shreg <= tx_buf;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
                  default: ;
               endcase
            end else if (scl_fall && cnt != 4'd0 && state == ST_RDAT) begin
               shreg <= {shreg[6:0], 1'b0};
            end
         end
      end
   end

   // R10: the open-drain enable only moves during the clock-low phase
   assert_sda_low_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   // R9: no acknowledge of the device address while programming
   assert_busy_no_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEV && byte_end && busy_i) |=> !sda_oe);

   // R11: a START always restarts address matching with SDA released
   assert_start_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_DEV && cnt == 4'd0 && !sda_oe));

   // R8: once ignoring traffic the line is never pulled
   assert_skip_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe);

   // R3: write strobes are single-cycle
   assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);
endmodule

// File: tb/test_ser_mem_target.sv
module test_ser_mem_target;
   localparam int CLK_P    = 10;
   localparam int Q        = 3;
   localparam int BUSY_CYC = 400;

   logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
   logic [2:0]  strap = 3'b101;
   logic        sda_oe, wr_valid, wr_commit, rd_en;
   logic [11:0] wr_addr, rd_addr;
   logic [7:0]  wr_data, rd_data;
   wire         sda_line = sda_m & ~sda_oe;

   int checks = 0, errors = 0, commits = 0, busy_left = 0, r10_viol = 0;
   logic [7:0]  wmem [int];
   logic [7:0]  pbuf [int];
   logic [11:0] wlog_a [$];
   logic [7:0]  wlog_d [$];
   logic        prev_oe = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ser_mem_target i_ser_mem_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
      .busy_i(busy), .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_commit(wr_commit), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data)
   );

   function automatic logic [7:0] pat(int a);
      return 8'((a * 7 + (a >> 8)) & 255);
   endfunction

   function automatic logic [7:0] memval(int a);
      if (wmem.exists(a)) return wmem[a];
      return pat(a);
   endfunction

   always @(posedge clk) if (rd_en) rd_data <= memval(int'(rd_addr));

   // Page engine model: collect bytes, program on commit, stay busy for a while
   always @(negedge clk) begin
      if (wr_valid) begin
         wlog_a.push_back(wr_addr);
         wlog_d.push_back(wr_data);
         pbuf[int'(wr_addr)] = wr_data;
      end
      if (wr_commit) begin
         commits++;
         foreach (pbuf[k]) wmem[k] = pbuf[k];
         pbuf.delete();
         busy_left = BUSY_CYC;
      end else if (busy_left > 0) begin
         busy_left--;
      end
      busy = (busy_left > 0);
   end

   always @(posedge clk) begin
      #1;
      if (rst_n && sda_oe !== prev_oe && scl) r10_viol++;
      prev_oe = sda_oe;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bstart();
      sda_m = 1'b1; tk(Q); scl = 1'b1; tk(Q); sda_m = 1'b0; tk(Q); scl = 1'b0; tk(Q);
   endtask

   task automatic bstop();
      sda_m = 1'b0; tk(Q); scl = 1'b1; tk(Q); sda_m = 1'b1; tk(Q);
   endtask

   task automatic bbit(input logic b);
      sda_m = b; tk(Q); scl = 1'b1; tk(2*Q); scl = 1'b0; tk(Q);
   endtask

   task automatic rbit(output logic b);
      sda_m = 1'b1; tk(Q); scl = 1'b1; tk(Q); b = sda_line; tk(Q); scl = 1'b0; tk(Q);
   endtask

   task automatic sendb(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) bbit(d[i]);
      rbit(b);
      ack = !b;
   endtask

   task automatic recvb(output logic [7:0] d, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         rbit(b);
         d[i] = b;
      end
      bbit(!give_ack);
   endtask

   task automatic hdr(input logic rd, output logic ack);
      sendb({4'b1010, strap, rd}, ack);
   endtask

   task automatic read_chk(input string req, input int a0, input int n);
      logic [7:0] d;
      for (int k = 0; k < n; k++) begin
         recvb(d, k < n - 1);
         chk(req, int'(d), int'(memval((a0 + k) & 12'hFFF)));
      end
   endtask

   task automatic cur_read(input string req, input int a);
      logic ack;
      bstart(); hdr(1'b1, ack);
      chk({req, " ack"}, int'(ack), 1);
      read_chk(req, a, 1);
      bstop();
   endtask

   task automatic rand_hdr(input int a, output logic ack);
      logic k;
      bstart(); hdr(1'b0, k);
      sendb(8'(a >> 8), k);
      sendb(8'(a), k);
      bstart(); hdr(1'b1, ack);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #(CLK_P * 150000);
      $display("FAIL watchdog expired");
      checks++;
      errors++;
      summary();
      $finish;
   end

   initial begin
      logic ack;
      logic [7:0] d;
      int polls;
      tk(4);
      // R12: reset state
      chk("R12 sda_oe", int'(sda_oe), 0);
      chk("R12 wr_valid", int'(wr_valid), 0);
      chk("R12 wr_commit", int'(wr_commit), 0);
      chk("R12 rd_en", int'(rd_en), 0);
      rst_n = 1'b1;
      tk(4);

      // R1, R5, R12: pointer starts at 0, then persists
      cur_read("R12 R1 R5 first read", 0);
      cur_read("R5 second read", 1);

      // R1: wrong strap gets no ACK and traffic is ignored
      bstart(); sendb({4'b1010, 3'b010, 1'b1}, ack);
      chk("R1 mismatch no ack", int'(ack), 0);
      sendb(8'h00, ack);
      chk("R1 ignored byte no ack", int'(ack), 0);
      bstop();
      cur_read("R1 pointer unchanged", 2);

      // R2, R3, R4: page write across the page boundary
      bstart(); hdr(1'b0, ack);
      chk("R1 write hdr ack", int'(ack), 1);
      sendb(8'hF1, ack); chk("R2 addr hi ack", int'(ack), 1);
      sendb(8'h3C, ack); chk("R2 addr lo ack", int'(ack), 1);
      for (int k = 0; k < 6; k++) begin
         sendb(8'hA0 + 8'(k), ack);
         chk("R3 data ack", int'(ack), 1);
      end
      bstop();
      tk(2);
      chk("R3 strobe count", wlog_a.size(), 6);
      for (int k = 0; k < 6; k++) begin
         chk("R2 R3 wr_addr", int'(wlog_a[k]), 'h100 | (('h3C + k) & 'h3F));
         chk("R3 wr_data", int'(wlog_d[k]), 'hA0 + k);
      end
      chk("R4 commit on STOP", commits, 1);

      // R9: polling while busy
      bstart(); hdr(1'b0, ack); bstop();
      chk("R9 no ack while busy", int'(ack), 0);
      polls = 0;
      ack = 1'b0;
      while (!ack && polls < 40) begin
         bstart(); hdr(1'b0, ack); bstop();
         polls++;
      end
      chk("R9 ack after busy", int'(ack), 1);
      chk("R4 no commit from header only", commits, 1);

      // R5, R3: pointer after page wrap
      cur_read("R5 R3 pointer after write", 'h102);

      // R6, R7: random + sequential read of written data
      rand_hdr('h13E, ack);
      chk("R6 read hdr ack", int'(ack), 1);
      read_chk("R6 R7 seq data", 'h13E, 4);
      bstop();

      // R7, R8: full-array wrap, then pointer after NACK
      rand_hdr('hFFE, ack);
      read_chk("R7 wrap data", 'hFFE, 4);
      bstop();
      cur_read("R8 pointer after NACK", 'h002);

      // R4: repeated START discards pending data
      bstart(); hdr(1'b0, ack);
      sendb(8'h08, ack); sendb(8'h00, ack); sendb(8'h55, ack);
      bstart(); hdr(1'b1, ack);
      read_chk("R4 R6 read after discard", 'h801, 1);
      bstop();
      tk(2);
      chk("R4 no commit on repeated START", commits, 1);
      chk("R4 busy stays low", int'(busy), 0);
      rand_hdr('h800, ack);
      recvb(d, 1'b0);
      chk("R4 byte not programmed", int'(d), int'(pat('h800)));
      bstop();

      // R11: START in mid-byte
      bstart();
      bbit(1'b1); bbit(1'b0); bbit(1'b1); bbit(1'b0);
      bstart(); hdr(1'b1, ack);
      chk("R11 ack after mid-byte START", int'(ack), 1);
      read_chk("R11 data after abort", 'h801, 1);
      bstop();
      // R11: STOP in mid-byte during an address byte
      bstart(); hdr(1'b0, ack);
      bbit(1'b0); bbit(1'b1); bbit(1'b1);
      bstop();
      cur_read("R11 pointer after mid-byte STOP", 'h802);

      chk("R10 sda_oe moved with SCL high", r10_viol, 0);
      summary();
      $finish;
   end
endmodule